// File: doc/BRIEF.md
# Cost-Aware Clean/Dirty Page Partition Manager

This block picks replacement frames for a page buffer of `NFRAMES` frames. Every resident page is either clean or dirty. The clean pages form one recency-ordered list and the dirty pages form another. A self-tuning target `tau` sets the size that the clean list should have. `tau` always lies between 0 and `NFRAMES`. The dirty list's target is the remainder, `NFRAMES - tau`.

Read hits on clean pages show that keeping clean pages saves device reads, so they raise `tau`. Write hits on dirty pages show that holding dirty pages saves device writes, so they lower `tau`. On a fault in a full buffer, `tau` decides which list gives up its least recently used page. Evicting a dirty page raises a write-back flag.

Each request carries a page tag and a read/write flag. One request may be presented per cycle. The response follows one cycle later and gives:
- hit or miss,
- the frame that now holds the page,
- whether a resident page was displaced, its tag, and whether it must be written back,
- the updated `tau`.

The block does not move any data.

Top module: `page_split_ctl`

## Requirements
- R1: After reset, `tau` equals `TAU_INIT` (default `NFRAMES/2`), `rsp_valid` is 0, and all frames are empty.
- R2: A request whose tag is resident responds one cycle later with `rsp_hit`=1, the frame holding the tag in `rsp_frame`, and `rsp_evict`=0. A cycle with `req_valid`=0 responds with `rsp_valid`=0.
- R3: A miss while any frame is empty fills the lowest-numbered empty frame, with `rsp_evict`=0 and `rsp_writeback`=0.
- R4: A read hit on a clean page raises `tau` by one, saturating at `NFRAMES`.
- R5: A write hit on a dirty page lowers `tau` by one, saturating at 0.
- R6: A read hit on a dirty page and a write hit on a clean page leave `tau` unchanged. A write hit on a clean page makes that page dirty.
- R7: On a miss with the buffer full, the least recently used clean page is the victim when the clean count exceeds `tau` or no dirty page exists. In that case `rsp_writeback`=0.
- R8: On any other full-buffer miss, the least recently used dirty page is the victim and `rsp_writeback`=1.
- R9: Every hit and every insertion makes the page the most recently used page of the list it ends up in.
- R10: On an eviction, `rsp_victim_tag` is the displaced tag and the new page takes over the victim's frame. A missed write inserts a dirty page and a missed read inserts a clean page.
- R11: Misses never change `tau`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_tag | input | TAG_W | Page tag requested |
| req_write | input | 1 | 1 = write request, 0 = read request |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Tag was resident |
| rsp_frame | output | $clog2(NFRAMES) | Frame now holding the requested page |
| rsp_evict | output | 1 | A resident page was displaced |
| rsp_victim_tag | output | TAG_W | Tag of the displaced page (0 if none) |
| rsp_writeback | output | 1 | Displaced page was dirty |
| tau | output | $clog2(NFRAMES+1) | Current clean-list target size |

## Verification
The directed sequences use four patterns:
- **Fill.** Mixed reads and writes go into an empty buffer. This separates free-frame allocation from eviction.
- **Hit mixes.** Every pairing of request type and page state is applied. This shows which pairings move `tau` and which only move recency; a write hit on a clean page is exposed later, when that page is chosen as a dirty victim.
- **Saturation runs.** Repeated clean read hits and repeated dirty write hits drive `tau` into both bounds.
- **Full-buffer misses.** These are issued with the clean count above, at, and below `tau`, including once with no dirty page resident. They tell the clean-victim path apart from the dirty-victim path and check which page in each list counts as least recent.

// File: rtl/page_split_ctl.sv
module page_split_ctl #(
  parameter int NFRAMES  = 4,
  parameter int TAG_W    = 8,
  parameter int TAU_INIT = NFRAMES / 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [TAG_W-1:0]             req_tag,
  input  logic                         req_write,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [$clog2(NFRAMES)-1:0]   rsp_frame,
  output logic                         rsp_evict,
  output logic [TAG_W-1:0]             rsp_victim_tag,
  output logic                         rsp_writeback,
  output logic [$clog2(NFRAMES+1)-1:0] tau
);
  localparam int FW = $clog2(NFRAMES);
  localparam int TW = $clog2(NFRAMES + 1);
  localparam logic [TW-1:0] TAU_MAX = TW'(NFRAMES);

  logic [NFRAMES-1:0] vld, drt;
  logic [TAG_W-1:0]   tag_q [NFRAMES];
  logic [FW-1:0]      age   [NFRAMES];
  logic [TW-1:0]      tau_q;

  logic          hit, free_any, lru_c_ok;
  logic [FW-1:0] hit_idx, free_idx, lru_c, lru_d, tgt;
  logic [TW-1:0] clean_cnt, dirty_cnt;
  logic          use_clean, evict, wb, tgt_dirty;
  logic [TW-1:0] tau_nx;

  always_comb begin
    hit = 1'b0; hit_idx = '0;
    free_any = 1'b0; free_idx = '0;
    clean_cnt = '0; dirty_cnt = '0;
    lru_c_ok = 1'b0; lru_c = '0;
    lru_d = '0;
    for (int i = NFRAMES - 1; i >= 0; i--) begin
      if (vld[i] && tag_q[i] == req_tag) begin
        hit = 1'b1;
        hit_idx = FW'(i);
      end
      if (!vld[i]) begin
        free_any = 1'b1;
        free_idx = FW'(i);
      end
    end
    for (int i = 0; i < NFRAMES; i++) begin
      if (vld[i] && !drt[i]) begin
        clean_cnt = clean_cnt + 1'b1;
        if (!lru_c_ok || age[i] > age[lru_c]) lru_c = FW'(i);
        lru_c_ok = 1'b1;
      end
      if (vld[i] && drt[i]) begin
        if (dirty_cnt == '0 || age[i] > age[lru_d]) lru_d = FW'(i);
        dirty_cnt = dirty_cnt + 1'b1;
      end
    end
  end

  assign use_clean = (clean_cnt > tau_q) || (dirty_cnt == '0);
  assign evict     = !hit && !free_any;
  assign wb        = evict && !use_clean;
  assign tgt       = hit ? hit_idx : (free_any ? free_idx : (use_clean ? lru_c : lru_d));
  assign tgt_dirty = req_write || (hit && drt[hit_idx]);

  always_comb begin
    tau_nx = tau_q;
    if (hit && !drt[hit_idx] && !req_write && tau_q != TAU_MAX) tau_nx = tau_q + 1'b1;
    if (hit &&  drt[hit_idx] &&  req_write && tau_q != '0)      tau_nx = tau_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= '0;
      drt   <= '0;
      tau_q <= TW'(TAU_INIT);
      for (int i = 0; i < NFRAMES; i++) begin
        tag_q[i] <= '0;
        age[i]   <= FW'(i);
      end
    end else if (req_valid) begin
      vld[tgt]   <= 1'b1;
      drt[tgt]   <= tgt_dirty;
      tag_q[tgt] <= req_tag;
      tau_q      <= tau_nx;
      for (int i = 0; i < NFRAMES; i++) begin
        if (FW'(i) == tgt)       age[i] <= '0;
        else if (age[i] < age[tgt]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_frame      <= '0;
      rsp_evict      <= 1'b0;
      rsp_victim_tag <= '0;
      rsp_writeback  <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_hit        <= req_valid && hit;
      rsp_frame      <= req_valid ? tgt : '0;
      rsp_evict      <= req_valid && evict;
      rsp_victim_tag <= (req_valid && evict) ? tag_q[tgt] : '0;
      rsp_writeback  <= req_valid && wb;
    end
  end

  assign tau = tau_q;
endmodule

// File: rtl/page_split_chk.sv
module page_split_chk #(
  parameter int NFRAMES = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic                         req_write,
  input logic                         rsp_valid,
  input logic                         rsp_hit,
  input logic                         rsp_evict,
  input logic                         rsp_writeback,
  input logic [$clog2(NFRAMES+1)-1:0] tau
);
  localparam int TW = $clog2(NFRAMES + 1);

  // R4
  tau_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tau <= TW'(NFRAMES));

  // R4
  tau_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tau > $past(tau) |-> rsp_hit && !$past(req_write) && tau == $past(tau) + 1'b1);

  // R5
  tau_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tau < $past(tau) |-> rsp_hit && $past(req_write) && tau + 1'b1 == $past(tau));

  // R11
  miss_tau_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> tau == $past(tau));

  // R8
  wb_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_writeback |-> rsp_evict && !rsp_hit);

  // R2
  hit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> !rsp_evict && rsp_valid);

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));
endmodule

bind page_split_ctl page_split_chk #(.NFRAMES(NFRAMES)) u_chk (.*);

// File: tb/page_split_ctl_test.sv
module page_split_ctl_test;
  localparam int N = 4;
  localparam int TAG_W = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [TAG_W-1:0] req_tag = '0;
  logic req_write = 0;
  logic rsp_valid, rsp_hit, rsp_evict, rsp_writeback;
  logic [1:0] rsp_frame;
  logic [TAG_W-1:0] rsp_victim_tag;
  logic [2:0] tau;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  page_split_ctl #(.NFRAMES(N), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_frame(rsp_frame), .rsp_evict(rsp_evict), .rsp_victim_tag(rsp_victim_tag),
    .rsp_writeback(rsp_writeback), .tau(tau));

  task automatic chk(string rq, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic [7:0] tg, input bit wr, input bit ehit, input int efr,
                        input bit eev, input int evt, input bit ewb, input int etau, input string rq);
    @(negedge clk);
    req_valid = 1; req_tag = tg; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    chk(rq, "rsp_valid", int'(rsp_valid), 1);
    chk(rq, "hit", int'(rsp_hit), int'(ehit));
    chk(rq, "frame", int'(rsp_frame), efr);
    chk(rq, "evict", int'(rsp_evict), int'(eev));
    chk(rq, "victim_tag", int'(rsp_victim_tag), evt);
    chk(rq, "writeback", int'(rsp_writeback), int'(ewb));
    chk(rq, "tau", int'(tau), etau);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", "tau", int'(tau), 2);
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_fill();
    access(8'h10, 0, 0, 0, 0, 0, 0, 2, "R3");
    access(8'h11, 0, 0, 1, 0, 0, 0, 2, "R3");
    access(8'h12, 1, 0, 2, 0, 0, 0, 2, "R3_R11");
    access(8'h13, 1, 0, 3, 0, 0, 0, 2, "R1_empty");
  endtask

  task automatic t_hits();
    access(8'h10, 0, 1, 0, 0, 0, 0, 3, "R4");
    access(8'h12, 1, 1, 2, 0, 0, 0, 2, "R5");
    access(8'h13, 0, 1, 3, 0, 0, 0, 2, "R6");
  endtask

  task automatic t_victims();
    access(8'h20, 0, 0, 2, 1, 8'h12, 1, 2, "R8");
    access(8'h21, 0, 0, 1, 1, 8'h11, 0, 2, "R7_R9");
  endtask

  task automatic t_write_clean();
    access(8'h10, 1, 1, 0, 0, 0, 0, 2, "R6");
    access(8'h22, 1, 0, 3, 1, 8'h13, 1, 2, "R10");
    access(8'h23, 0, 0, 0, 1, 8'h10, 1, 2, "R6");
  endtask

  task automatic t_sat_up();
    access(8'h20, 0, 1, 2, 0, 0, 0, 3, "R4");
    access(8'h21, 0, 1, 1, 0, 0, 0, 4, "R4");
    access(8'h23, 0, 1, 0, 0, 0, 0, 4, "R4");
  endtask

  task automatic t_no_dirty();
    access(8'h24, 0, 0, 3, 1, 8'h22, 1, 4, "R8");
    access(8'h25, 0, 0, 2, 1, 8'h20, 0, 4, "R7");
  endtask

  task automatic t_sat_down();
    access(8'h21, 1, 1, 1, 0, 0, 0, 4, "R6");
    access(8'h21, 1, 1, 1, 0, 0, 0, 3, "R5");
    access(8'h21, 1, 1, 1, 0, 0, 0, 2, "R5");
    access(8'h21, 1, 1, 1, 0, 0, 0, 1, "R5");
    access(8'h21, 1, 1, 1, 0, 0, 0, 0, "R5");
    access(8'h21, 1, 1, 1, 0, 0, 0, 0, "R5");
  endtask

  task automatic t_low_tau();
    access(8'h26, 0, 0, 0, 1, 8'h23, 0, 0, "R7");
    access(8'h26, 0, 1, 0, 0, 0, 0, 1, "R10");
  endtask

  task automatic t_idle();
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    chk("R2", "idle rsp_valid", int'(rsp_valid), 0);
    chk("R2", "idle tau", int'(tau), 1);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_hits();
    t_victims();
    t_write_clean();
    t_sat_up();
    t_no_dirty();
    t_sat_down();
    t_low_tau();
    t_idle();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule